// File: doc/BRIEF.md
# Two-Phase Hybrid Self-Test Wrapper

This block wraps one combinational core and runs a self-test on it in two consecutive phases. In the first phase an internal linear feedback shift register generates a new pseudorandom pattern every clock, and that pattern drives the core for a programmed number of cycles. In the second phase the wrapper switches every core input through a 2:1 multiplexer to precomputed deterministic patterns. These patterns arrive over a valid/ready stream from memory or a tester, and each one may take several clocks to arrive.

Every applied pattern's core response is folded into one multiple-input signature register. That register is seeded at start and runs across both phases without being cleared. When the last response has been captured, the wrapper raises done and holds the final signature. It also compares the signature with an expected value and reports pass or fail.

A test starts with a start pulse. The same pulse samples the pseudorandom length, the deterministic count and both seeds.

Top module: `hybrid_bist_wrap`

## Requirements
- R1: After reset, done_o, det_ready_o and pass_o are low and sig_o is zero.
- R2: start_i is accepted only while idle or done. An accepted start loads both seeds, the pseudorandom length and the deterministic count. A start while a test runs has no effect on the stimulus sequence, the signature or the completion cycle.
- R3: In the pseudorandom phase core_stim_o equals the generator state for prand_len_i consecutive cycles, and det_ready_o stays low. The first pattern is the seed. The generator steps as a right shift: when the old bit 0 is 1, the shifted value is XORed with LFSR_TAPS (default 16'hB400). A zero seed is replaced by 1.
- R4: With the default taps the generator sequence is maximal length: it returns to its seed after exactly 2^16-1 steps and not before.
- R5: In the deterministic phase det_ready_o is high and core_stim_o equals det_pat_i. A pattern is applied in each cycle where det_valid_i is high, until det_count_i patterns have been applied. A pseudorandom length of zero starts directly in this phase.
- R6: A cycle in the deterministic phase with det_valid_i low applies nothing: the signature does not change and the pattern count does not advance.
- R7: The signature is loaded with sig_seed_i at start. On each applied pattern it becomes ((s >> 1) XOR (s[0] ? MISR_TAPS : 0)) XOR core_resp_i, with MISR_TAPS defaulting to 16'hB400. It is not cleared between the phases.
- R8: done_o rises in the cycle after the last pattern is applied and stays high until the next accepted start.
- R9: A deterministic count of zero skips the second phase: det_ready_o never rises and done_o follows the last pseudorandom pattern.
- R10: pass_o is high exactly when done_o is high and sig_o equals expect_sig_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a test run |
| prand_len_i | input | CNT_W | Number of pseudorandom patterns |
| det_count_i | input | CNT_W | Number of deterministic patterns |
| lfsr_seed_i | input | STIM_W | Generator seed |
| sig_seed_i | input | RESP_W | Signature seed |
| det_pat_i | input | STIM_W | Deterministic pattern data |
| det_valid_i | input | 1 | Deterministic pattern valid |
| det_ready_o | output | 1 | Wrapper accepts deterministic patterns |
| core_stim_o | output | STIM_W | Stimulus to the core inputs |
| core_resp_i | input | RESP_W | Core response |
| expect_sig_i | input | RESP_W | Expected final signature |
| sig_o | output | RESP_W | Current signature |
| done_o | output | 1 | Test complete |
| pass_o | output | 1 | Final signature matches the expected value |

## Verification
Runs combine both phases with deterministic patterns that arrive every cycle or with gaps. The gapped runs separate real stalls from patterns that were dropped or captured twice. Runs with a zero pseudorandom length or a zero deterministic count check that each phase can be skipped cleanly. A full-period run with a zero seed checks the substitution to 1 and that the seed comes back only after 2^16-1 steps. A wrong expected signature, and a start pulse in the middle of a run, check the compare and that an in-flight start is ignored.

// File: rtl/hbist_pkg.sv
package hbist_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRAND,
    ST_DETER,
    ST_FIN
  } bist_state_e;
endpackage

// File: rtl/hbist_lfsr.sv
module hbist_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         adv_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= ONE;
    else if (load_i) q <= (seed_i == '0) ? ONE : seed_i;
    else if (adv_i)  q <= (q >> 1) ^ (q[0] ? TAPS : '0);
  end

  assign q_o = q;

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0);
endmodule

// File: rtl/hbist_misr.sv
module hbist_misr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         cap_i,
  input  logic [W-1:0] resp_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= seed_i;
    else if (cap_i)  q <= ((q >> 1) ^ (q[0] ? TAPS : '0)) ^ resp_i;
  end

  assign q_o = q;

  // R7
  misr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q == $past(seed_i));

  // R6
  misr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !cap_i) |=> $stable(q));
endmodule

// File: rtl/hbist_ctrl.sv
module hbist_ctrl
  import hbist_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] prand_len_i,
  input  logic [CNT_W-1:0] det_count_i,
  input  logic             det_valid_i,
  output logic             load_o,
  output logic             prand_o,
  output logic             deter_o,
  output logic             cap_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  bist_state_e      state_q;
  logic [CNT_W-1:0] pr_cnt_q, det_cnt_q;
  logic             start_acc;

  assign start_acc = start_i && (state_q == ST_IDLE || state_q == ST_FIN);
  assign load_o    = start_acc;
  assign prand_o   = state_q == ST_PRAND;
  assign deter_o   = state_q == ST_DETER;
  assign done_o    = state_q == ST_FIN;
  assign cap_o     = prand_o || (deter_o && det_valid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pr_cnt_q  <= '0;
      det_cnt_q <= '0;
    end else if (start_acc) begin
      pr_cnt_q  <= prand_len_i;
      det_cnt_q <= det_count_i;
      if (prand_len_i != '0)      state_q <= ST_PRAND;
      else if (det_count_i != '0) state_q <= ST_DETER;
      else                        state_q <= ST_FIN;
    end else begin
      unique case (state_q)
        ST_PRAND: begin
          pr_cnt_q <= pr_cnt_q - ONE;
          if (pr_cnt_q == ONE)
            state_q <= (det_cnt_q != '0) ? ST_DETER : ST_FIN;
        end
        ST_DETER: begin
          if (det_valid_i) begin
            det_cnt_q <= det_cnt_q - ONE;
            if (det_cnt_q == ONE) state_q <= ST_FIN;
          end
        end
        default: ;
      endcase
    end
  end

  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  // R2
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prand_o && start_i && pr_cnt_q != ONE) |=> prand_o);
endmodule

// File: rtl/hybrid_bist_wrap.sv
module hybrid_bist_wrap #(
  parameter int                STIM_W    = 16,
  parameter int                RESP_W    = 16,
  parameter int                CNT_W     = 16,
  parameter logic [STIM_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [RESP_W-1:0] MISR_TAPS = 16'hB400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  prand_len_i,
  input  logic [CNT_W-1:0]  det_count_i,
  input  logic [STIM_W-1:0] lfsr_seed_i,
  input  logic [RESP_W-1:0] sig_seed_i,
  input  logic [STIM_W-1:0] det_pat_i,
  input  logic              det_valid_i,
  output logic              det_ready_o,
  output logic [STIM_W-1:0] core_stim_o,
  input  logic [RESP_W-1:0] core_resp_i,
  input  logic [RESP_W-1:0] expect_sig_i,
  output logic [RESP_W-1:0] sig_o,
  output logic              done_o,
  output logic              pass_o
);
  logic              load, prand, deter, cap, done;
  logic [STIM_W-1:0] lfsr_q;

  hbist_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .prand_len_i (prand_len_i),
    .det_count_i (det_count_i),
    .det_valid_i (det_valid_i),
    .load_o      (load),
    .prand_o     (prand),
    .deter_o     (deter),
    .cap_o       (cap),
    .done_o      (done)
  );

  hbist_lfsr #(.W(STIM_W), .TAPS(LFSR_TAPS)) i_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .seed_i (lfsr_seed_i),
    .adv_i  (prand),
    .q_o    (lfsr_q)
  );

  hbist_misr #(.W(RESP_W), .TAPS(MISR_TAPS)) i_misr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .seed_i (sig_seed_i),
    .cap_i  (cap),
    .resp_i (core_resp_i),
    .q_o    (sig_o)
  );

  // one 2:1 select per core input
  for (genvar b = 0; b < STIM_W; b++) begin : g_in_mux
    assign core_stim_o[b] = deter ? det_pat_i[b] : lfsr_q[b];
  end

  assign det_ready_o = deter;
  assign done_o      = done;
  assign pass_o      = done && (sig_o == expect_sig_i);

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_ready_o && !det_valid_i && !start_i) |=> $stable(sig_o));

  // R8
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(cap) || $past(load)));

  // R9
  ready_not_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(det_ready_o && done_o));
endmodule

// File: tb/test_hybrid_bist_wrap.sv
module test_hybrid_bist_wrap;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam logic [W-1:0] TAPS = 16'hB400;

  logic         clk = 0, rst_ni = 0;
  logic         start = 0, det_valid = 0;
  logic [W-1:0] prand_len = 0, det_count = 0, lseed = 0, mseed = 0;
  logic [W-1:0] det_pat = 0, exp_sig = 0;
  logic         det_ready, done, pass;
  logic [W-1:0] stim, resp, sig;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model of the core under test
  assign resp = {stim[12:0], stim[15:13]} ^ 16'h5A3C ^ {8'h00, stim[15:8]};

  hybrid_bist_wrap i_hybrid_bist_wrap (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .prand_len_i(prand_len), .det_count_i(det_count),
    .lfsr_seed_i(lseed), .sig_seed_i(mseed),
    .det_pat_i(det_pat), .det_valid_i(det_valid), .det_ready_o(det_ready),
    .core_stim_o(stim), .core_resp_i(resp), .expect_sig_i(exp_sig),
    .sig_o(sig), .done_o(done), .pass_o(pass)
  );

  function automatic logic [W-1:0] step(logic [W-1:0] s);
    return (s >> 1) ^ (s[0] ? TAPS : '0);
  endfunction

  function automatic logic [W-1:0] core_fn(logic [W-1:0] s);
    return {s[12:0], s[15:13]} ^ 16'h5A3C ^ {8'h00, s[15:8]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // one full run; gap: valid low every gap-th det cycle (0 = none)
  task automatic run(input int pr, input int dc, input logic [W-1:0] ls, input logic [W-1:0] ms,
                     input int gap, input int busy_start_at, input bit bad_exp, input bit count_seed);
    logic [W-1:0] lfsr_m, misr_m, pat;
    int pr_left, det_left, cyc, seed_hits, dcyc;
    bit running;
    @(negedge clk);
    prand_len = W'(pr); det_count = W'(dc); lseed = ls; mseed = ms; start = 1;
    lfsr_m = (ls == '0) ? 16'h0001 : ls;
    misr_m = ms;
    pr_left = pr; det_left = dc; cyc = 0; dcyc = 0; seed_hits = 0; running = 1;
    while (running) begin
      @(negedge clk);
      cyc++;
      start = (cyc == busy_start_at);
      exp_sig = 0;
      if (pr_left > 0) begin
        det_valid = 0;
        #1;
        chk(det_ready == 0, "R3 ready in prand", 32'(det_ready), 0);
        chk(stim == lfsr_m, "R3 prand stimulus", 32'(stim), 32'(lfsr_m));
        chk(sig == misr_m, "R7 signature", 32'(sig), 32'(misr_m));
        chk(done == 0, "R8 done early", 32'(done), 0);
        if (count_seed && stim == ((ls == '0) ? 16'h0001 : ls)) seed_hits++;
        misr_m = step(misr_m) ^ core_fn(lfsr_m);
        lfsr_m = step(lfsr_m);
        pr_left--;
      end else if (det_left > 0) begin
        dcyc++;
        det_valid = !(gap != 0 && (dcyc % gap) == 0);
        pat = 16'hC3A5 ^ W'(dcyc * 257);
        det_pat = pat;
        #1;
        chk(det_ready == 1, "R5 ready in deter", 32'(det_ready), 1);
        chk(sig == misr_m, "R6 R7 signature", 32'(sig), 32'(misr_m));
        chk(done == 0, "R8 done early", 32'(done), 0);
        if (det_valid) begin
          chk(stim == pat, "R5 deter stimulus", 32'(stim), 32'(pat));
          misr_m = step(misr_m) ^ core_fn(pat);
          det_left--;
        end
      end else begin
        det_valid = 0;
        #1;
        chk(done == 1, "R8 done after last", 32'(done), 1);
        chk(det_ready == 0, "R9 ready after end", 32'(det_ready), 0);
        chk(sig == misr_m, "R7 final signature", 32'(sig), 32'(misr_m));
        exp_sig = bad_exp ? ~misr_m : misr_m;
        #1;
        chk(pass == !bad_exp, "R10 pass compare", 32'(pass), 32'(!bad_exp));
        if (count_seed) begin
          chk(seed_hits == 1, "R4 seed repeats early", 32'(seed_hits), 1);
          chk(stim == lfsr_m && lfsr_m == ((ls == '0) ? 16'h0001 : ls), "R4 period", 32'(stim), 32'(lfsr_m));
        end
        running = 0;
      end
    end
    start = 0;
    @(negedge clk);
    chk(done == 1, "R8 done holds", 32'(done), 1);
  endtask

  task automatic t_reset();
    #1;
    chk(done == 0, "R1 done", 32'(done), 0);
    chk(det_ready == 0, "R1 ready", 32'(det_ready), 0);
    chk(pass == 0, "R1 pass", 32'(pass), 0);
    chk(sig == 0, "R1 sig", 32'(sig), 0);
  endtask

  task automatic t_both_phases();    run(5, 3, 16'hACE1, 16'h1234, 0, 0, 0, 0); endtask
  task automatic t_gapped();         run(4, 5, 16'h0F0F, 16'hBEEF, 3, 0, 0, 0); endtask
  task automatic t_busy_start();     run(6, 4, 16'h7777, 16'h0001, 2, 3, 0, 0); endtask
  task automatic t_no_prand();       run(0, 3, 16'h1111, 16'h8001, 2, 0, 0, 0); endtask
  task automatic t_no_deter_r9();    run(7, 0, 16'h2468, 16'h4321, 0, 0, 0, 0); endtask
  task automatic t_wrong_expect();   run(3, 2, 16'h5555, 16'hFFFF, 0, 0, 1, 0); endtask
  task automatic t_full_period_r4(); run(65535, 0, 16'h0000, 16'h0BAD, 0, 0, 0, 1); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    #(CLK_PERIOD * 2);
    @(negedge clk);
    rst_ni = 1;
    t_both_phases();
    t_gapped();
    t_busy_start();
    t_no_prand();
    t_no_deter_r9();
    t_wrong_expect();
    t_full_period_r4();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule